// File: doc/BRIEF.md
# Memory Operand Address Decoder

This block takes in, one byte at a time, the addressing bytes of an instruction, starting with the operand-form byte that follows the opcode. For each instruction it reports the decoded addressing description: a base register, an index register with a scale, and a displacement. If the instruction names a register operand directly, it reports that register instead. It also reports the reg/spare field and the number of addressing bytes it consumed. Opcode decoding happens upstream. The upstream logic presents the address width (16 or 32 bit) and the three register-extension bits of any extension prefix together with the first byte. The address adder downstream uses the result.

The input is a stream of bytes qualified by a valid signal. Cycles where the valid signal is low are stalls. The block walks through three states: operand-form byte, optional scale/index/base byte, and displacement bytes. Displacement bytes arrive least significant first. When the last byte of an instruction has been taken, a one-cycle done pulse presents every decoded field. A new instruction may start in the very next cycle.

Top module: `ea_addr_decoder`

## Requirements
- R1: The first byte is split as mode = bits 7:6, spare = bits 5:3 and rm = bits 2:0. `reg_o` is {extension R, spare} in both address widths.
- R2: Mode 3 is a direct register operand. `direct_o`=1, `base_o`={extension B, rm}, both valid flags are 0, the displacement is 0 and the length is 1.
- R3: At 32-bit width, mode 0, 1 and 2 take 0, 1 and 4 displacement bytes. Mode 0 with rm 5 gives a 4-byte displacement with no base and no index, whatever the value of extension B.
- R4: At 32-bit width, rm 4 (mode not 3) means a second byte follows, with scale = bits 7:6 (factor 1, 2, 4, 8 coded 0 to 3), index = {X, bits 5:3} and base = {B, bits 2:0}. An index of exactly 4 means no index. With X set, an index field of 4 selects register 12.
- R5: When that second byte has base bits 2:0 = 5 and the mode is 0, there is no base and a 4-byte displacement follows, while the index is still reported. With mode 1 or 2, base 5 is a valid base.
- R6: At 16-bit width the second byte is never used. rm 0 to 7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX, with register numbers BX=3, BP=5, SI=6, DI=7 and scale 0. Mode 0, 1 and 2 take 0, 1 and 2 displacement bytes.
- R7: At 16-bit width, mode 0 with rm 6 gives a 2-byte displacement with no base and no index.
- R8: Extension B extends rm or base at 32-bit width and for direct operands. It is ignored for 16-bit memory forms.
- R9: The displacement is assembled least significant byte first. One-byte displacements are sign-extended to 32 bits. Two-byte displacements are zero-extended.
- R10: `done_o` is high for the one cycle after the edge that takes the last addressing byte. `len_o` then gives the total number of bytes consumed (1 to 6).
- R11: A cycle with `byte_valid_i` low consumes nothing and changes no decoding progress.
- R12: While `rst_ni` is low, `done_o` is 0 and no byte is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit; sampled with the first byte |
| rex_rxb_i | input | 3 | Extension bits {R, X, B}, zero when there is no prefix; sampled with the first byte |
| byte_valid_i | input | 1 | `byte_i` holds an addressing byte this cycle |
| byte_i | input | 8 | Addressing byte |
| done_o | output | 1 | One-cycle pulse: the fields below describe a finished instruction |
| direct_o | output | 1 | Operand is the register on `base_o` |
| reg_o | output | 4 | Extended spare/reg field |
| base_valid_o | output | 1 | A base register is used |
| base_o | output | 4 | Base register, or the direct register |
| index_valid_o | output | 1 | An index register is used |
| index_o | output | 4 | Index register |
| scale_o | output | 2 | Index scale code (factor 2^code) |
| disp_o | output | 32 | Displacement, extended to 32 bits |
| len_o | output | 3 | Addressing bytes consumed |

## Verification
The assertions check four things on every done cycle. A direct operand carries one byte and no memory registers. Index register 4 never comes out as valid. A form with no base and no index always consumed at least three bytes. The length stays between 1 and 6. A further assertion checks that a stall cycle can never produce done. Only the bench scenarios can show the actual register numbers, the escape cases for displacement only and for a missing base, the effect of the extension bits, byte order and sign extension, and the exact lengths. These depend on specific byte values, so the bench checks them against hand-derived expectations, including stalls placed in the middle of an instruction.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int REG_W = 4;
  localparam int LEN_W = 3;

  typedef enum logic [1:0] {
    EA_FORM,
    EA_SIB,
    EA_DISP
  } ea_state_e;

  localparam logic [2:0] R16_BX = 3'd3;
  localparam logic [2:0] R16_BP = 3'd5;
  localparam logic [2:0] R16_SI = 3'd6;
  localparam logic [2:0] R16_DI = 3'd7;

  typedef struct packed {
    logic             base_vld;
    logic [REG_W-1:0] base;
    logic             idx_vld;
    logic [REG_W-1:0] idx;
  } ea_regs_t;
endpackage

// File: rtl/ea_form_dec.sv
module ea_form_dec
  import ea_pkg::*;
(
  input  logic [7:0]       form_i,
  input  logic             mode32_i,
  input  logic             ext_r_i,
  input  logic             ext_b_i,
  output logic             direct_o,
  output logic [REG_W-1:0] reg_o,
  output logic             sib_o,
  output logic [2:0]       dlen_o,
  output ea_regs_t         regs_o
);
  logic [1:0] md;
  logic [2:0] rm;
  assign md = form_i[7:6];
  assign rm = form_i[2:0];
  assign reg_o = {ext_r_i, form_i[5:3]};

  always_comb begin
    direct_o = 1'b0;
    sib_o    = 1'b0;
    dlen_o   = 3'd0;
    regs_o   = '0;
    if (md == 2'd3) begin
      direct_o    = 1'b1;
      regs_o.base = {ext_b_i, rm};
    end else if (mode32_i) begin
      unique case (md)
        2'd1:    dlen_o = 3'd1;
        2'd2:    dlen_o = 3'd4;
        default: dlen_o = 3'd0;
      endcase
      if (rm == 3'd4) begin
        sib_o = 1'b1;
      end else if (md == 2'd0 && rm == 3'd5) begin
        dlen_o = 3'd4;  // displacement only
      end else begin
        regs_o.base_vld = 1'b1;
        regs_o.base     = {ext_b_i, rm};
      end
    end else begin
      unique case (md)
        2'd1:    dlen_o = 3'd1;
        2'd2:    dlen_o = 3'd2;
        default: dlen_o = 3'd0;
      endcase
      if (md == 2'd0 && rm == 3'd6) begin
        dlen_o = 3'd2;  // displacement only
      end else begin
        regs_o.base_vld = 1'b1;
        if (!rm[2]) begin
          regs_o.idx_vld = 1'b1;
          regs_o.base    = {1'b0, rm[1] ? R16_BP : R16_BX};
          regs_o.idx     = {1'b0, rm[0] ? R16_DI : R16_SI};
        end else begin
          unique case (rm[1:0])
            2'd0:    regs_o.base = {1'b0, R16_SI};
            2'd1:    regs_o.base = {1'b0, R16_DI};
            2'd2:    regs_o.base = {1'b0, R16_BP};
            default: regs_o.base = {1'b0, R16_BX};
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ea_sib_dec.sv
module ea_sib_dec
  import ea_pkg::*;
(
  input  logic [7:0] sib_i,
  input  logic [1:0] mode_i,
  input  logic       ext_x_i,
  input  logic       ext_b_i,
  output logic [1:0] scale_o,
  output ea_regs_t   regs_o,
  output logic       disp4_o
);
  logic [REG_W-1:0] idx_full;
  assign idx_full = {ext_x_i, sib_i[5:3]};
  assign scale_o  = sib_i[7:6];
  // base escape looks at the low three bits only
  assign disp4_o  = (mode_i == 2'd0) && (sib_i[2:0] == 3'd5);

  always_comb begin
    regs_o.idx_vld  = (idx_full != REG_W'(4));
    regs_o.idx      = idx_full;
    regs_o.base_vld = !disp4_o;
    regs_o.base     = {ext_b_i, sib_i[2:0]};
  end
endmodule

// File: rtl/ea_disp_acc.sv
module ea_disp_acc #(
  parameter int NBYTES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [7:0]                 byte_i,
  output logic [$clog2(NBYTES+1)-1:0] cnt_o,
  output logic [8*NBYTES-1:0]        val_o
);
  localparam int CW = $clog2(NBYTES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            val_o[8*g +: 8] <= '0;
      else if (clr_i)                         val_o[8*g +: 8] <= '0;
      else if (push_i && cnt_q == CW'(g))     val_o[8*g +: 8] <= byte_i;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ea_addr_decoder.sv
module ea_addr_decoder
  import ea_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic [2:0]        rex_rxb_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              done_o,
  output logic              direct_o,
  output logic [REG_W-1:0]  reg_o,
  output logic              base_valid_o,
  output logic [REG_W-1:0]  base_o,
  output logic              index_valid_o,
  output logic [REG_W-1:0]  index_o,
  output logic [1:0]        scale_o,
  output logic [DISP_W-1:0] disp_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int DISP_BYTES = DISP_W / 8;
  localparam int CNT_W      = $clog2(DISP_BYTES + 1);

  ea_state_e        state_q;
  logic [1:0]       mode_q;
  logic             ext_x_q, ext_b_q;
  logic [CNT_W-1:0] dlen_q;
  logic             direct_q, done_q;
  logic [REG_W-1:0] reg_q;
  ea_regs_t         regs_q;
  logic [1:0]       scale_q;
  logic [LEN_W-1:0] len_q;

  logic             f_direct, f_sib;
  logic [REG_W-1:0] f_reg;
  logic [2:0]       f_dlen;
  ea_regs_t         f_regs;
  logic [1:0]       s_scale;
  ea_regs_t         s_regs;
  logic             s_disp4;
  logic [CNT_W-1:0] acc_cnt;
  logic [DISP_W-1:0] acc_val;
  logic             take_form, take_disp, last_disp;

  ea_form_dec u_form (
    .form_i   (byte_i),
    .mode32_i (mode32_i),
    .ext_r_i  (rex_rxb_i[2]),
    .ext_b_i  (rex_rxb_i[0]),
    .direct_o (f_direct),
    .reg_o    (f_reg),
    .sib_o    (f_sib),
    .dlen_o   (f_dlen),
    .regs_o   (f_regs)
  );

  ea_sib_dec u_sib (
    .sib_i   (byte_i),
    .mode_i  (mode_q),
    .ext_x_i (ext_x_q),
    .ext_b_i (ext_b_q),
    .scale_o (s_scale),
    .regs_o  (s_regs),
    .disp4_o (s_disp4)
  );

  assign take_form = byte_valid_i && (state_q == EA_FORM);
  assign take_disp = byte_valid_i && (state_q == EA_DISP);
  assign last_disp = (acc_cnt + 1'b1) == dlen_q;

  ea_disp_acc #(.NBYTES(DISP_BYTES)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take_form),
    .push_i (take_disp),
    .byte_i (byte_i),
    .cnt_o  (acc_cnt),
    .val_o  (acc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= EA_FORM;
      mode_q   <= '0;
      ext_x_q  <= 1'b0;
      ext_b_q  <= 1'b0;
      dlen_q   <= '0;
      direct_q <= 1'b0;
      done_q   <= 1'b0;
      reg_q    <= '0;
      regs_q   <= '0;
      scale_q  <= '0;
      len_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (byte_valid_i) begin
        unique case (state_q)
          EA_FORM: begin
            mode_q   <= byte_i[7:6];
            ext_x_q  <= rex_rxb_i[1];
            ext_b_q  <= rex_rxb_i[0];
            direct_q <= f_direct;
            reg_q    <= f_reg;
            regs_q   <= f_regs;
            scale_q  <= '0;
            dlen_q   <= CNT_W'(f_dlen);
            len_q    <= LEN_W'(1);
            if (f_sib)             state_q <= EA_SIB;
            else if (f_dlen != '0) state_q <= EA_DISP;
            else                   done_q  <= 1'b1;
          end
          EA_SIB: begin
            regs_q  <= s_regs;
            scale_q <= s_scale;
            len_q   <= len_q + 1'b1;
            if (s_disp4) begin
              dlen_q  <= CNT_W'(4);
              state_q <= EA_DISP;
            end else if (dlen_q != '0) begin
              state_q <= EA_DISP;
            end else begin
              done_q  <= 1'b1;
              state_q <= EA_FORM;
            end
          end
          default: begin
            len_q <= len_q + 1'b1;
            if (last_disp) begin
              done_q  <= 1'b1;
              state_q <= EA_FORM;
            end
          end
        endcase
      end
    end
  end

  assign done_o        = done_q;
  assign direct_o      = direct_q;
  assign reg_o         = reg_q;
  assign base_valid_o  = regs_q.base_vld;
  assign base_o        = regs_q.base;
  assign index_valid_o = regs_q.idx_vld;
  assign index_o       = regs_q.idx;
  assign scale_o       = scale_q;
  assign len_o         = len_q;
  assign disp_o        = (dlen_q == CNT_W'(1)) ? {{(DISP_W-8){acc_val[7]}}, acc_val[7:0]}
                                               : acc_val;
endmodule

// File: rtl/ea_addr_decoder_chk.sv
module ea_addr_decoder_chk
  import ea_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic              done_o,
  input logic              direct_o,
  input logic              base_valid_o,
  input logic              index_valid_o,
  input logic [REG_W-1:0]  index_o,
  input logic [DISP_W-1:0] disp_o,
  input logic [LEN_W-1:0]  len_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (!done_o); // R12
  end

  AST_STALL_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !done_o); // R11

  AST_DIRECT_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && direct_o |-> len_o == LEN_W'(1) && !base_valid_o && !index_valid_o && disp_o == '0); // R2

  AST_NO_INDEX_FOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && index_valid_o |-> index_o != REG_W'(4)); // R4

  AST_DISP_ONLY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !direct_o && !base_valid_o && !index_valid_o |-> len_o >= LEN_W'(3)); // R3

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> len_o >= LEN_W'(1) && len_o <= LEN_W'(6)); // R10
endmodule

bind ea_addr_decoder ea_addr_decoder_chk #(.DISP_W(DISP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_valid_i  (byte_valid_i),
  .done_o        (done_o),
  .direct_o      (direct_o),
  .base_valid_o  (base_valid_o),
  .index_valid_o (index_valid_o),
  .index_o       (index_o),
  .disp_o        (disp_o),
  .len_o         (len_o)
);

// File: tb/ea_addr_decoder_bench.sv
`timescale 1ns/1ps
module ea_addr_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode32_i = 1'b1;
  logic [2:0]  rex_rxb_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        done_o, direct_o, base_valid_o, index_valid_o;
  logic [3:0]  reg_o, base_o, index_o;
  logic [1:0]  scale_o;
  logic [31:0] disp_o;
  logic [2:0]  len_o;

  always #2.5 clk_i = ~clk_i;

  ea_addr_decoder u_ea_addr_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode32_i(mode32_i), .rex_rxb_i(rex_rxb_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .done_o(done_o), .direct_o(direct_o),
    .reg_o(reg_o), .base_valid_o(base_valid_o), .base_o(base_o),
    .index_valid_o(index_valid_o), .index_o(index_o), .scale_o(scale_o),
    .disp_o(disp_o), .len_o(len_o)
  );

  typedef struct {
    string      tag;
    bit         dr;
    bit [3:0]   rg;
    bit         bv;
    bit [3:0]   b;
    bit         iv;
    bit [3:0]   ix;
    bit [1:0]   sc;
    bit [31:0]  d;
    int         len;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(string tag, bit dr, bit [3:0] rg, bit bv, bit [3:0] b,
                              bit iv, bit [3:0] ix, bit [1:0] sc, bit [31:0] d, int len);
    exp_t e;
    e.tag = tag; e.dr = dr; e.rg = rg; e.bv = bv; e.b = b;
    e.iv = iv; e.ix = ix; e.sc = sc; e.d = d; e.len = len;
    return e;
  endfunction

  // monitor: pops one expectation per done pulse
  always @(negedge clk_i) begin
    if (rst_ni && done_o && !finished) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "direct", 32'(direct_o), 32'(e.dr));
        chk(e.tag, "reg", 32'(reg_o), 32'(e.rg));
        chk(e.tag, "base_valid", 32'(base_valid_o), 32'(e.bv));
        if (e.bv || e.dr) chk(e.tag, "base", 32'(base_o), 32'(e.b));
        chk(e.tag, "index_valid", 32'(index_valid_o), 32'(e.iv));
        if (e.iv) chk(e.tag, "index", 32'(index_o), 32'(e.ix));
        chk(e.tag, "scale", 32'(scale_o), 32'(e.sc));
        chk(e.tag, "disp", disp_o, e.d);
        chk({e.tag, "/R10"}, "len", 32'(len_o), 32'(e.len));
      end
    end
  end

  // driver: seq holds bytes, first byte in bits 7:0; stall idles after each byte (R11)
  task automatic send(bit m32, bit [2:0] rxb, logic [47:0] seq, int n, int stall, exp_t e);
    q.push_back(e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      mode32_i = m32; rex_rxb_i = rxb; byte_valid_i = 1'b1; byte_i = seq[8*i +: 8];
      for (int s = 0; s < stall; s++) begin
        @(negedge clk_i);
        byte_valid_i = 1'b0; byte_i = 8'hC0;  // would finish a direct form if taken
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    byte_valid_i = 1'b1; byte_i = 8'hC0;
    repeat (3) @(negedge clk_i);
    chk("R12", "done in reset", 32'(done_o), 32'd0);
    byte_valid_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R12", "done after reset", 32'(done_o), 32'd0);

    send(1, 3'b000, 48'hC1, 1, 0, mk("R2", 1, 0, 0, 1, 0, 0, 0, 0, 1));
    send(1, 3'b101, 48'hDA, 1, 0, mk("R2", 1, 11, 0, 10, 0, 0, 0, 0, 1));
    send(1, 3'b000, 48'h38, 1, 0, mk("R1", 0, 7, 1, 0, 0, 0, 0, 0, 1));
    send(1, 3'b000, 48'h12345678_05, 5, 2, mk("R3", 0, 0, 0, 0, 0, 0, 0, 32'h12345678, 5));
    send(1, 3'b000, 48'hF046, 2, 0, mk("R9", 0, 0, 1, 6, 0, 0, 0, 32'hFFFFFFF0, 2));
    send(1, 3'b000, 48'h80000001_81, 5, 0, mk("R3", 0, 0, 1, 1, 0, 0, 0, 32'h80000001, 5));
    send(1, 3'b000, 48'h8B04, 2, 1, mk("R4", 0, 0, 1, 3, 1, 1, 2, 0, 2));
    send(1, 3'b000, 48'h102044, 3, 0, mk("R4", 0, 0, 1, 0, 0, 0, 0, 32'h10, 3));
    send(1, 3'b000, 48'hCAFEBABE_D504, 6, 2, mk("R5", 0, 0, 0, 0, 1, 2, 3, 32'hCAFEBABE, 6));
    send(1, 3'b000, 48'h7F2544, 3, 0, mk("R5", 0, 0, 1, 5, 0, 0, 0, 32'h7F, 3));
    send(1, 3'b011, 48'h6104, 2, 0, mk("R8", 0, 0, 1, 9, 1, 12, 1, 0, 2));
    send(1, 3'b001, 48'h00000000_05, 5, 0, mk("R3", 0, 0, 0, 0, 0, 0, 0, 0, 5));
    send(1, 3'b001, 48'h03, 1, 0, mk("R8", 0, 0, 1, 11, 0, 0, 0, 0, 1));
    send(1, 3'b001, 48'h052544, 3, 0, mk("R5", 0, 0, 1, 13, 0, 0, 0, 32'h5, 3));
    send(0, 3'b000, 48'h00, 1, 0, mk("R6", 0, 0, 1, 3, 1, 6, 0, 0, 1));
    send(0, 3'b000, 48'hBEEF06, 3, 2, mk("R7", 0, 0, 0, 0, 0, 0, 0, 32'h0000BEEF, 3));
    send(0, 3'b000, 48'h8046, 2, 0, mk("R9", 0, 0, 1, 5, 0, 0, 0, 32'hFFFFFF80, 2));
    send(0, 3'b000, 48'h123483, 3, 0, mk("R6", 0, 0, 1, 5, 1, 7, 0, 32'h1234, 3));
    send(0, 3'b111, 48'h04, 1, 3, mk("R8", 0, 8, 1, 6, 0, 0, 0, 0, 1));

    @(negedge clk_i);
    byte_valid_i = 1'b0; byte_i = 8'hC0;
    repeat (6) @(negedge clk_i);
    chk("R10", "pending results", 32'(q.size()), 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule